// File: doc/BRIEF.md
# Mapped Priority Interrupt Controller

This block collects 64 event sources and folds them down to 10 interrupt lines in two mapping stages. Each event keeps a sticky pending bit, which sets either from a hardware source or from a software trigger. A per-event enable gates whether that pending bit takes part in arbitration. An enabled pending event is steered to one of 10 channels by an 8-bit map field. Each channel is then steered to one of 10 hosts by a second 8-bit map field. Both stages resolve contention by index: the lowest-numbered source wins.

The top 32 events come from level inputs outside the block. Events 16 to 31 can be raised by two processor cores. Each core presents a 4-bit vector together with a valid strobe, and the strobes of both cores are combined by OR. Events 0 to 15 can only be raised by software.

Hosts 0 and 1 are handed back to the cores as status bits. Hosts 2 to 9 leave the block as interrupt lines. Software reaches all state through a single-cycle word bus. It can read a per-host word that names the winning event.

Register word addresses are fixed. Status words are at 0 and 1. Enable words are at 2 and 3. Pend-by-index is at 4, unpend-by-index at 5, enable-by-index at 6 and disable-by-index at 7. The host enable word is at 8. The event-to-channel map occupies words 16 to 31. The channel-to-host map occupies words 32 to 34. The per-host winner words occupy 40 to 49.

Top module: `evmap_intc`

## Requirements
- R1: A high level on `ext_evt[k]` at a clock edge makes pending bit 32+k read as 1 after that edge. Pending bits are sticky: a bit never falls except through an unpend write or reset. Status word 0 holds events 31..0 and word 1 holds events 63..32.
- R2: A core whose `core_vld` bit is high at an edge pends event 16+v, where v is that core's 4-bit field of `core_vec`. Both cores may pend in the same cycle. A vector presented with its valid bit low pends nothing.
- R3: Writing an index to word 4 pends that event, and writing it to word 5 clears it. An index of 64 or more is ignored. If a hardware source is high in the same cycle as the unpend write, the bit stays set.
- R4: Writing an index to word 6 enables that event and writing it to word 7 disables it. Enable words 2 and 3 are also readable and writable as whole words. A disabled event stays visible in status but reaches no host.
- R5: Event i uses the byte at bits 8*(i mod 4)+7 : 8*(i mod 4) of word 16 + i/4 to select its channel. A value of 10 or more sends the event to no channel.
- R6: Channel c uses the byte at bits 8*(c mod 4)+7 : 8*(c mod 4) of word 32 + c/4 to select its host. Bytes that do not correspond to a channel read as 0.
- R7: When several enabled pending events are on one channel, the lowest-numbered event represents that channel.
- R8: When several channels carrying enabled pending events map to one host, the lowest-numbered channel wins, even when its event number is higher.
- R9: Word 40+h reads the winning event index of host h in bits 5:0 with bit 31 clear. It reads 0x8000_0000 when nothing reaches host h. This word does not depend on the host enable.
- R10: Bits 9:0 of word 8 enable the hosts. A host line is high only when the host is enabled and some enabled pending event reaches it. Hosts 0 and 1 drive `core_irq[1:0]` and hosts 2 to 9 drive `ext_irq[7:0]`, combinationally from registered state.
- R11: After reset, all of the following are zero: pending bits, enables, map fields, host enables and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_evt | input | 32 | Level event inputs for events 32..63 |
| core_vld | input | 2 | Per-core event valid strobe |
| core_vec | input | 8 | Per-core 4-bit event vector, core 0 in bits 3:0 |
| core_irq | output | 2 | Host 0 and host 1 lines returned to the cores |
| ext_irq | output | 8 | Host 2..9 lines |

## Verification
A pending bit that is lost or set wrongly shows up in the status words on the very next read. It also changes the host line on the cycle after the edge. A wrong map decode or a wrong priority chain shows up the moment two sources contend: the winner word of the host names the wrong event. It does so in the same cycle that the second source becomes pending. A gating fault shows up as a host line that disagrees with the winner word and the host enable. The directed scenarios therefore read the winner word after every single pend, unpend or remap step.

// File: rtl/evmap_pkg.sv
package evmap_pkg;

    localparam int unsigned MAP_W      = 8;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned A_STAT     = 0;
    localparam int unsigned A_ENAB     = 2;
    localparam int unsigned A_PEND     = 4;
    localparam int unsigned A_UNPEND   = 5;
    localparam int unsigned A_ENIDX    = 6;
    localparam int unsigned A_DISIDX   = 7;
    localparam int unsigned A_HOSTEN   = 8;
    localparam int unsigned A_CHMAP    = 16;
    localparam int unsigned A_HOSTMAP  = 32;
    localparam int unsigned A_WINNER   = 40;
    localparam logic [WORD_W-1:0] NO_WINNER = 32'h8000_0000;

    typedef struct packed {
        logic       we;
        logic [7:0] idx;
    } idx_cmd_t;

endpackage

// File: rtl/evmap_event_bank.sv
module evmap_event_bank
    import evmap_pkg::*;
#(
    parameter int unsigned N_EVT     = 64,
    parameter int unsigned N_EXT     = 32,
    parameter int unsigned N_CORE    = 2,
    parameter int unsigned VEC_W     = 4,
    parameter int unsigned CORE_BASE = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_EXT-1:0]         ext_evt,
    input  logic [N_CORE-1:0]        core_vld,
    input  logic [N_CORE*VEC_W-1:0]  core_vec,
    input  idx_cmd_t                 pend_cmd,
    input  idx_cmd_t                 unpend_cmd,
    input  idx_cmd_t                 enset_cmd,
    input  idx_cmd_t                 enclr_cmd,
    input  logic [N_EVT/32-1:0]      en_word_we,
    input  logic [31:0]              en_word_data,
    output logic [N_EVT-1:0]         status_q,
    output logic [N_EVT-1:0]         enable_q
);

    localparam int unsigned IDX_W = $clog2(N_EVT);
    localparam int unsigned EN_WORDS = N_EVT / 32;

    logic [N_EVT-1:0] core_set, hw_set;
    logic [N_EVT-1:0] pend_m, unpend_m, enset_m, enclr_m;
    logic [N_EVT-1:0] status_d, enable_d;

    always_comb begin
        core_set = '0;
        for (int c = 0; c < N_CORE; c++) begin
            if (core_vld[c]) begin
                core_set[IDX_W'(CORE_BASE) + IDX_W'(core_vec[c*VEC_W +: VEC_W])] = 1'b1;
            end
        end
        hw_set = core_set | {ext_evt, {(N_EVT-N_EXT){1'b0}}};
    end

    function automatic logic [N_EVT-1:0] idx_mask(idx_cmd_t cmd);
        if (cmd.we && (cmd.idx < N_EVT)) return N_EVT'(1) << cmd.idx;
        return '0;
    endfunction

    always_comb begin
        pend_m   = idx_mask(pend_cmd);
        unpend_m = idx_mask(unpend_cmd);
        enset_m  = idx_mask(enset_cmd);
        enclr_m  = idx_mask(enclr_cmd);
        status_d = (status_q & ~unpend_m) | hw_set | pend_m;
        enable_d = enable_q;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (en_word_we[w]) enable_d[w*32 +: 32] = en_word_data;
        end
        enable_d = (enable_d | enset_m) & ~enclr_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    AST_EXT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt != '0) |=> ((status_q[N_EVT-1 -: N_EXT] & $past(ext_evt)) == $past(ext_evt))); // R1

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !unpend_cmd.we |=> (($past(status_q) & ~status_q) == '0)); // R1

    AST_UNPEND_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (unpend_cmd.we && !pend_cmd.we && (unpend_cmd.idx < N_EVT) && !hw_set[unpend_cmd.idx[IDX_W-1:0]])
        |=> !status_q[$past(unpend_cmd.idx[IDX_W-1:0])]); // R3

    for (genvar c = 0; c < N_CORE; c++) begin : g_core_chk
        AST_CORE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
            core_vld[c] |=> status_q[IDX_W'(CORE_BASE) + IDX_W'($past(core_vec[c*VEC_W +: VEC_W]))]); // R2
    end

endmodule

// File: rtl/evmap_chan_prio.sv
module evmap_chan_prio
    import evmap_pkg::*;
#(
    parameter int unsigned N_EVT = 64,
    parameter int unsigned N_CH  = 10,
    parameter int unsigned IDX_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_EVT-1:0]       active,
    input  logic [N_EVT*MAP_W-1:0] ch_map,
    output logic [N_CH-1:0]        ch_hit,
    output logic [N_CH*IDX_W-1:0]  ch_idx
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [N_EVT-1:0] cand;
        logic             hit;
        logic [IDX_W-1:0] idx;

        always_comb begin
            for (int e = 0; e < N_EVT; e++) begin
                cand[e] = active[e] && (ch_map[e*MAP_W +: MAP_W] == MAP_W'(c));
            end
        end

        always_comb begin
            hit = 1'b0;
            idx = '0;
            for (int e = N_EVT - 1; e >= 0; e--) begin
                if (cand[e]) begin
                    hit = 1'b1;
                    idx = IDX_W'(e);
                end
            end
        end

        assign ch_hit[c] = hit;
        assign ch_idx[c*IDX_W +: IDX_W] = idx;

        AST_CH_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (cand[idx] && ((cand & ((N_EVT'(1) << idx) - N_EVT'(1))) == '0))); // R7
    end

endmodule

// File: rtl/evmap_host_prio.sv
module evmap_host_prio
    import evmap_pkg::*;
#(
    parameter int unsigned N_CH   = 10,
    parameter int unsigned N_HOST = 10,
    parameter int unsigned IDX_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CH-1:0]         ch_hit,
    input  logic [N_CH*IDX_W-1:0]   ch_idx,
    input  logic [N_CH*MAP_W-1:0]   host_map,
    output logic [N_HOST-1:0]       host_hit,
    output logic [N_HOST*IDX_W-1:0] host_idx
);

    localparam int unsigned CHX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    for (genvar h = 0; h < N_HOST; h++) begin : g_host
        logic [N_CH-1:0]  cand;
        logic             hit;
        logic [CHX_W-1:0] win;
        logic [IDX_W-1:0] idx;

        always_comb begin
            for (int c = 0; c < N_CH; c++) begin
                cand[c] = ch_hit[c] && (host_map[c*MAP_W +: MAP_W] == MAP_W'(h));
            end
        end

        always_comb begin
            hit = 1'b0;
            win = '0;
            idx = '0;
            for (int c = N_CH - 1; c >= 0; c--) begin
                if (cand[c]) begin
                    hit = 1'b1;
                    win = CHX_W'(c);
                    idx = ch_idx[c*IDX_W +: IDX_W];
                end
            end
        end

        assign host_hit[h] = hit;
        assign host_idx[h*IDX_W +: IDX_W] = idx;

        AST_HOST_LOWEST_CH: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (cand[win] && ((cand & ((N_CH'(1) << win) - N_CH'(1))) == '0))); // R8
    end

endmodule

// File: rtl/evmap_intc.sv
module evmap_intc
    import evmap_pkg::*;
#(
    parameter int unsigned N_EVT     = 64,
    parameter int unsigned N_EXT     = 32,
    parameter int unsigned N_CH      = 10,
    parameter int unsigned N_HOST    = 10,
    parameter int unsigned N_CORE    = 2,
    parameter int unsigned CORE_HOST = 2,
    parameter int unsigned VEC_W     = 4,
    parameter int unsigned CORE_BASE = 16,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [N_EXT-1:0]           ext_evt,
    input  logic [N_CORE-1:0]          core_vld,
    input  logic [N_CORE*VEC_W-1:0]    core_vec,
    output logic [CORE_HOST-1:0]       core_irq,
    output logic [N_HOST-CORE_HOST-1:0] ext_irq
);

    localparam int unsigned IDX_W    = $clog2(N_EVT);
    localparam int unsigned EN_WORDS = N_EVT / 32;

    logic [N_EVT-1:0]        status_q, enable_q, active;
    logic [N_EVT*MAP_W-1:0]  chmap_q;
    logic [N_CH*MAP_W-1:0]   hostmap_q;
    logic [N_HOST-1:0]       hosten_q, host_hit, host_irq;
    logic [N_CH-1:0]         ch_hit;
    logic [N_CH*IDX_W-1:0]   ch_idx;
    logic [N_HOST*IDX_W-1:0] host_idx;
    idx_cmd_t                pend_cmd, unpend_cmd, enset_cmd, enclr_cmd;
    logic [EN_WORDS-1:0]     en_word_we;

    function automatic logic hit_addr(logic [ADDR_W-1:0] a, int unsigned w);
        return a == ADDR_W'(w);
    endfunction

    always_comb begin
        pend_cmd   = '{we: bus_we && hit_addr(bus_addr, A_PEND),   idx: bus_wdata[7:0]};
        unpend_cmd = '{we: bus_we && hit_addr(bus_addr, A_UNPEND), idx: bus_wdata[7:0]};
        enset_cmd  = '{we: bus_we && hit_addr(bus_addr, A_ENIDX),  idx: bus_wdata[7:0]};
        enclr_cmd  = '{we: bus_we && hit_addr(bus_addr, A_DISIDX), idx: bus_wdata[7:0]};
        for (int w = 0; w < EN_WORDS; w++) begin
            en_word_we[w] = bus_we && hit_addr(bus_addr, A_ENAB + w);
        end
    end

    evmap_event_bank #(
        .N_EVT(N_EVT), .N_EXT(N_EXT), .N_CORE(N_CORE),
        .VEC_W(VEC_W), .CORE_BASE(CORE_BASE)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt),
        .core_vld(core_vld), .core_vec(core_vec),
        .pend_cmd(pend_cmd), .unpend_cmd(unpend_cmd),
        .enset_cmd(enset_cmd), .enclr_cmd(enclr_cmd),
        .en_word_we(en_word_we), .en_word_data(bus_wdata),
        .status_q(status_q), .enable_q(enable_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chmap_q   <= '0;
            hostmap_q <= '0;
            hosten_q  <= '0;
        end else if (bus_we) begin
            for (int f = 0; f < N_EVT; f++) begin
                if (hit_addr(bus_addr, A_CHMAP + f / 4))
                    chmap_q[f*MAP_W +: MAP_W] <= bus_wdata[(f%4)*MAP_W +: MAP_W];
            end
            for (int f = 0; f < N_CH; f++) begin
                if (hit_addr(bus_addr, A_HOSTMAP + f / 4))
                    hostmap_q[f*MAP_W +: MAP_W] <= bus_wdata[(f%4)*MAP_W +: MAP_W];
            end
            if (hit_addr(bus_addr, A_HOSTEN)) hosten_q <= bus_wdata[N_HOST-1:0];
        end
    end

    assign active = status_q & enable_q;

    evmap_chan_prio #(.N_EVT(N_EVT), .N_CH(N_CH), .IDX_W(IDX_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .active(active), .ch_map(chmap_q),
        .ch_hit(ch_hit), .ch_idx(ch_idx)
    );

    evmap_host_prio #(.N_CH(N_CH), .N_HOST(N_HOST), .IDX_W(IDX_W)) u_host (
        .clk(clk), .rst_n(rst_n), .ch_hit(ch_hit), .ch_idx(ch_idx),
        .host_map(hostmap_q), .host_hit(host_hit), .host_idx(host_idx)
    );

    assign host_irq = host_hit & hosten_q;
    assign core_irq = host_irq[CORE_HOST-1:0];
    assign ext_irq  = host_irq[N_HOST-1:CORE_HOST];

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (hit_addr(bus_addr, A_STAT + w)) bus_rdata = status_q[w*32 +: 32];
            if (hit_addr(bus_addr, A_ENAB + w)) bus_rdata = enable_q[w*32 +: 32];
        end
        if (hit_addr(bus_addr, A_HOSTEN)) bus_rdata[N_HOST-1:0] = hosten_q;
        for (int f = 0; f < N_EVT; f++) begin
            if (hit_addr(bus_addr, A_CHMAP + f / 4))
                bus_rdata[(f%4)*MAP_W +: MAP_W] = chmap_q[f*MAP_W +: MAP_W];
        end
        for (int f = 0; f < N_CH; f++) begin
            if (hit_addr(bus_addr, A_HOSTMAP + f / 4))
                bus_rdata[(f%4)*MAP_W +: MAP_W] = hostmap_q[f*MAP_W +: MAP_W];
        end
        for (int h = 0; h < N_HOST; h++) begin
            if (hit_addr(bus_addr, A_WINNER + h))
                bus_rdata = host_hit[h] ? {{(32-IDX_W){1'b0}}, host_idx[h*IDX_W +: IDX_W]} : NO_WINNER;
        end
    end

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_irq != '0) || (ext_irq != '0)) |-> (active != '0)); // R10

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hosten_q == '0) |-> ((core_irq == '0) && (ext_irq == '0))); // R10

endmodule

// File: tb/evmap_intc_tb_top.sv
`timescale 1ns/1ps
module evmap_intc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] ext_evt = '0;
    logic [1:0]  core_vld = '0;
    logic [7:0]  core_vec = '0;
    logic [1:0]  core_irq;
    logic [7:0]  ext_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [31:0] NONE = 32'h8000_0000;

    always #2 clk = ~clk;

    evmap_intc dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_evt(ext_evt),
        .core_vld(core_vld), .core_vec(core_vec), .core_irq(core_irq), .ext_irq(ext_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 6'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v);  check("R11 status0", v, 0);
        rd(3, v);  check("R11 enable1", v, 0);
        rd(8, v);  check("R11 host enable", v, 0);
        rd(16, v); check("R11 chmap word", v, 0);
        rd(40, v); check("R9 winner empty", v, NONE);
        check("R11 irq lines", {22'd0, core_irq, ext_irq}, 0);
    endtask

    task automatic t_ext_event();
        logic [31:0] v;
        wr(8, 32'h1);
        wr(6, 40);
        @(negedge clk); ext_evt[8] = 1'b1;
        @(negedge clk); ext_evt[8] = 1'b0;
        #1;
        rd(1, v); check("R1 latched", v, 32'h100);
        check("R10 host0 line", {30'd0, core_irq}, 2'b01);
        repeat (3) @(negedge clk);
        rd(1, v); check("R1 sticky", v, 32'h100);
        rd(40, v); check("R9 winner 40", v, 40);
        wr(5, 40);
        rd(1, v); check("R3 unpend", v, 0);
        rd(40, v); check("R9 winner cleared", v, NONE);
        check("R10 host0 off", {30'd0, core_irq}, 0);
        wr(7, 40); wr(8, 0);
    endtask

    task automatic t_core_vec();
        logic [31:0] v;
        @(negedge clk); core_vld = 2'b10; core_vec = 8'h50;
        @(negedge clk); core_vld = 2'b00;
        #1; rd(0, v); check("R2 core1 vec5", v, 32'h0020_0000);
        core_vec = 8'h07;
        @(negedge clk); @(negedge clk);
        #1; rd(0, v); check("R2 no valid", v, 32'h0020_0000);
        @(negedge clk); core_vld = 2'b11; core_vec = 8'h92;
        @(negedge clk); core_vld = 2'b00; core_vec = 8'h00;
        #1; rd(0, v); check("R2 both cores", v, 32'h0224_0000);
        wr(5, 21); wr(5, 18); wr(5, 25);
        rd(0, v); check("R3 core events cleared", v, 0);
    endtask

    task automatic t_sw_trigger();
        logic [31:0] v;
        wr(4, 3);
        rd(0, v); check("R3 pend by index", v, 32'h8);
        wr(5, 3);
        rd(0, v); check("R3 unpend by index", v, 0);
        wr(4, 70);
        rd(0, v); check("R3 out of range low", v, 0);
        rd(1, v); check("R3 out of range high", v, 0);
        @(negedge clk); ext_evt[0] = 1'b1;
        wr(5, 32);
        rd(1, v); check("R3 hw set beats unpend", v, 32'h1);
        ext_evt[0] = 1'b0;
        wr(5, 32);
        rd(1, v); check("R3 unpend after release", v, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(8, 32'h1);
        wr(4, 5);
        rd(0, v); check("R4 pending while disabled", v, 32'h20);
        rd(40, v); check("R4 disabled no winner", v, NONE);
        check("R4 disabled no line", {30'd0, core_irq}, 0);
        wr(6, 5);
        rd(2, v); check("R4 enable word", v, 32'h20);
        rd(40, v); check("R4 enabled winner", v, 5);
        check("R4 enabled line", {30'd0, core_irq}, 2'b01);
        wr(7, 5);
        check("R4 disabled again", {30'd0, core_irq}, 0);
        wr(3, 32'h0000_F00F);
        rd(3, v); check("R4 enable word write", v, 32'h0000_F00F);
        wr(3, 0); wr(5, 5); wr(8, 0);
    endtask

    task automatic t_chan_prio();
        logic [31:0] v;
        wr(18, 32'h0004_0000);
        wr(17, 32'h0400_0000);
        wr(33, 32'h0000_0005);
        wr(8, 32'h20);
        wr(6, 7); wr(6, 10);
        rd(18, v); check("R5 chmap readback", v, 32'h0004_0000);
        wr(4, 10);
        rd(45, v); check("R7 single on channel", v, 10);
        check("R10 host5 line", {24'd0, ext_irq}, 8'h08);
        wr(4, 7);
        rd(45, v); check("R7 lower event wins", v, 7);
        wr(5, 7);
        rd(45, v); check("R7 fallback", v, 10);
        wr(5, 10); wr(7, 7); wr(7, 10);
        rd(45, v); check("R9 host5 empty", v, NONE);
        wr(18, 0); wr(17, 0); wr(33, 0); wr(8, 0);
    endtask

    task automatic t_host_prio();
        logic [31:0] v;
        wr(16, 32'h0003_0000);
        wr(28, 32'h0001_0000);
        wr(32, 32'h0200_0200);
        wr(8, 32'h4);
        wr(6, 2); wr(6, 50);
        wr(4, 2);
        rd(42, v); check("R8 one channel", v, 2);
        check("R10 host2 line", {24'd0, ext_irq}, 8'h01);
        wr(4, 50);
        rd(42, v); check("R8 lower channel wins", v, 50);
        wr(28, 32'h000C_0000);
        rd(42, v); check("R5 unmapped channel", v, 2);
        wr(8, 0);
        check("R10 host disabled", {24'd0, ext_irq}, 0);
        rd(42, v); check("R9 winner ignores host enable", v, 2);
        wr(32, 32'h0100_0200);
        wr(8, 32'h2);
        check("R10 host1 to core", {30'd0, core_irq}, 2'b10);
        rd(41, v); check("R6 remapped host", v, 2);
        wr(34, 32'hFFFF_0909);
        rd(34, v); check("R6 partial word", v, 32'h0000_0909);
        wr(5, 2); wr(5, 50); wr(7, 2); wr(7, 50);
        wr(16, 0); wr(28, 0); wr(32, 0); wr(34, 0); wr(8, 0);
    endtask

    initial begin
        #200_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ext_event();
        t_core_vec();
        t_sw_trigger();
        t_enable();
        t_chan_prio();
        t_host_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule